// File: doc/BRIEF.md
# Slice-Based Bitmap On-Screen-Display Overlay

This block lays a small bitmap on-screen display over a passing video stream. The bitmap is not a linear framebuffer. It is a pool of 48 vertical slices, and each slice is 8 pixels wide and 32 rows tall, with 2 bits per pixel. A separate ordered list of slice codes decides which slice appears in each 8-pixel column of the window. To redraw a counter or a clock, the host only has to reorder entries in that list.

The video timing supplies a pixel column and a line number together with each input sample. The block finds the window slot and the slice row for that position. It reads the slice code from the sequence table and the 16-bit row word from the slice store, and then takes out the 2-bit pixel code. Code 0 lets the video pass through. Codes 1, 2 and 3 replace the video with one of three programmable colours. A double-height option shows every bitmap row on two display lines.

The mixing decision is held in a small state machine. **MIX_IDLE** is the state after reset and drives zero. From any state, every clock goes to **MIX_PASS** when the pixel is transparent. It goes to **MIX_C1**, **MIX_C2** or **MIX_C3** when pixel code 1, 2 or 3 is found inside the window. The output process picks the delayed video or a colour register according to the state.

Top module: `osd_slice_overlay`

## Requirements
- R1: While reset is held, and in the cycle that follows it, `vid_out` and `vid_out_valid` are 0. Reset sets all sequence entries to code 63 and clears the control register, so the output is the input video until the host programs the block.
- R2: `vid_out_valid` equals `vid_valid` from one clock earlier. `vid_out` is always the result for the inputs presented one clock earlier.
- R3: Pixel code 0 is transparent, and `vid_out` is then the previous `vid_in`. Codes 1, 2 and 3 output colour register 1, 2 and 3.
- R4: Within a 16-bit slice row word, pixel k (k = 0 is the leftmost) sits in bits [15-2k:14-2k].
- R5: Sequence slot s covers window columns 8s to 8s+7, counted from the X start. The slice shown there is the code written into slot s, so reordering the codes moves the bitmaps.
- R6: Without double height, the window covers columns X start to X start+351 and lines Y start to Y start+31, with OSD row = line - Y start. Every pixel outside the window is transparent.
- R7: With double height, the window covers lines Y start to Y start+63, with OSD row = (line - Y start) / 2.
- R8: A slot whose code is 48 or more is transparent across its whole width.
- R9: A host write with `host_we` = 1 goes where `host_addr[12:11]` points.
  - Region 0 is the slice store, with index slice*32+row in `host_addr[10:0]`.
  - Region 1 is the sequence table, with the slot in `host_addr[10:0]` and the code in `host_wdata[5:0]`.
  - Region 2 is the register set, selected by `host_addr[2:0]`: 0 is X start, 1 is Y start, 2 to 4 are colours 1 to 3, and 5 is control (bit 0 display enable, bit 1 double height).
  - Slice indices of 1536 or more and slot numbers of 44 or more are ignored.
- R10: When the display enable bit is 0, `vid_out` is the previous `vid_in` at every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 13 | Host write address (region in bits 12:11) |
| host_wdata | input | 16 | Host write data |
| pix_x | input | 10 | Column of the current input sample |
| line_y | input | 10 | Line of the current input sample |
| vid_in | input | 16 | Incoming video sample |
| vid_valid | input | 1 | Incoming sample valid |
| vid_out | output | 16 | Mixed video sample |
| vid_out_valid | output | 1 | Mixed sample valid |

## Verification
Every video result is due exactly one clock after its inputs are presented, because the mixing state and the delayed copy of the video are the only registers on that path. A host write takes effect at the clock edge that captures it. The bench therefore drives each sample on a falling edge and samples the outputs shortly after the next rising edge. It performs host writes only between sweeps, while no checked sample is in flight. Each sampled value is compared with the colour or passthrough value that the bench computes from its own copy of the slice contents and the sequence codes, for that column and line.

// File: rtl/osd_pkg.sv
package osd_pkg;

    typedef enum logic [2:0] {
        MIX_IDLE,
        MIX_PASS,
        MIX_C1,
        MIX_C2,
        MIX_C3
    } mix_state_e;

    localparam logic [1:0] RGN_SLICE = 2'd0;
    localparam logic [1:0] RGN_SEQ   = 2'd1;
    localparam logic [1:0] RGN_REG   = 2'd2;

    localparam logic [2:0] REG_XSTART = 3'd0;
    localparam logic [2:0] REG_YSTART = 3'd1;
    localparam logic [2:0] REG_COL1   = 3'd2;
    localparam logic [2:0] REG_COL2   = 3'd3;
    localparam logic [2:0] REG_COL3   = 3'd4;
    localparam logic [2:0] REG_CTRL   = 3'd5;

endpackage

// File: rtl/osd_slice_store.sv
module osd_slice_store #(
    parameter int NUM_SLICES = 48,
    parameter int SLICE_H    = 32,
    parameter int WORD_W     = 16,
    localparam int DEPTH     = NUM_SLICES * SLICE_H,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int CODE_W    = $clog2(NUM_SLICES),
    localparam int ROW_W     = $clog2(SLICE_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [CODE_W-1:0] rd_code,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] bits_q [DEPTH];
    logic [IDX_W-1:0]  rd_idx;
    logic              wr_ok;

    assign wr_ok = wr_en && (wr_idx < IDX_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            bits_q[wr_idx] <= wr_word;
        end
    end

    always_comb begin
        rd_idx  = IDX_W'(int'(rd_code) * SLICE_H + int'(rd_row));
        rd_word = '0;
        if (rd_code < CODE_W'(NUM_SLICES)) begin
            rd_word = bits_q[rd_idx];
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> bits_q[$past(wr_idx)] == $past(wr_word)); // R9

endmodule

// File: rtl/osd_host_regs.sv
module osd_host_regs
    import osd_pkg::*;
#(
    parameter int NUM_SLOTS = 44,
    parameter int CODE_W    = 6,
    parameter int CRD_W     = 10,
    parameter int VID_W     = 16,
    parameter int IDX_W     = 11,
    parameter int HD_W      = 16,
    localparam int HA_W     = IDX_W + 2,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [HD_W-1:0]   host_wdata,
    input  logic [SLOT_W-1:0] slot_rd,
    output logic [CODE_W-1:0] code_rd,
    output logic [CRD_W-1:0]  x_start,
    output logic [CRD_W-1:0]  y_start,
    output logic [VID_W-1:0]  colour1,
    output logic [VID_W-1:0]  colour2,
    output logic [VID_W-1:0]  colour3,
    output logic              osd_en,
    output logic              dbl_h,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [HD_W-1:0]   mem_word
);

    logic [CODE_W-1:0] seq_q [NUM_SLOTS];
    logic [1:0]        region;
    logic [IDX_W-1:0]  low_idx;
    logic              seq_we;
    logic              reg_we;

    assign region   = host_addr[HA_W-1:HA_W-2];
    assign low_idx  = host_addr[IDX_W-1:0];
    assign mem_we   = host_we && (region == RGN_SLICE);
    assign mem_idx  = low_idx;
    assign mem_word = host_wdata;
    assign seq_we   = host_we && (region == RGN_SEQ) && (low_idx < IDX_W'(NUM_SLOTS));
    assign reg_we   = host_we && (region == RGN_REG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                seq_q[i] <= '1;
            end
        end else if (seq_we) begin
            seq_q[SLOT_W'(low_idx)] <= host_wdata[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_start <= '0;
            y_start <= '0;
            colour1 <= '0;
            colour2 <= '0;
            colour3 <= '0;
            osd_en  <= 1'b0;
            dbl_h   <= 1'b0;
        end else if (reg_we) begin
            unique case (host_addr[2:0])
                REG_XSTART: x_start <= host_wdata[CRD_W-1:0];
                REG_YSTART: y_start <= host_wdata[CRD_W-1:0];
                REG_COL1:   colour1 <= host_wdata[VID_W-1:0];
                REG_COL2:   colour2 <= host_wdata[VID_W-1:0];
                REG_COL3:   colour3 <= host_wdata[VID_W-1:0];
                REG_CTRL: begin
                    osd_en <= host_wdata[0];
                    dbl_h  <= host_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        code_rd = '1;
        if (slot_rd < SLOT_W'(NUM_SLOTS)) begin
            code_rd = seq_q[slot_rd];
        end
    end

endmodule

// File: rtl/osd_window_locate.sv
module osd_window_locate #(
    parameter int CRD_W     = 10,
    parameter int SLICE_W   = 8,
    parameter int SLICE_H   = 32,
    parameter int NUM_SLOTS = 44,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ROW_W    = $clog2(SLICE_H),
    localparam int PIX_W    = $clog2(SLICE_W),
    localparam int WIN_W    = NUM_SLOTS * SLICE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CRD_W-1:0]  pix_x,
    input  logic [CRD_W-1:0]  line_y,
    input  logic [CRD_W-1:0]  x_start,
    input  logic [CRD_W-1:0]  y_start,
    input  logic              osd_en,
    input  logic              dbl_h,
    output logic              in_win,
    output logic [SLOT_W-1:0] slot,
    output logic [ROW_W-1:0]  row,
    output logic [PIX_W-1:0]  pix
);

    logic [CRD_W:0] rel_x;
    logic [CRD_W:0] rel_y;
    logic [CRD_W:0] v_span;
    logic           h_in;
    logic           v_in;

    always_comb begin
        rel_x  = {1'b0, pix_x} - {1'b0, x_start};
        rel_y  = {1'b0, line_y} - {1'b0, y_start};
        v_span = dbl_h ? (CRD_W+1)'(2 * SLICE_H) : (CRD_W+1)'(SLICE_H);
        h_in   = (pix_x >= x_start) && (rel_x < (CRD_W+1)'(WIN_W));
        v_in   = (line_y >= y_start) && (rel_y < v_span);
        in_win = osd_en && h_in && v_in;
        slot   = SLOT_W'(rel_x >> PIX_W);
        pix    = rel_x[PIX_W-1:0];
        row    = dbl_h ? ROW_W'(rel_y >> 1) : ROW_W'(rel_y);
    end

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> slot < SLOT_W'(NUM_SLOTS)); // R5

    AST_DBL_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && dbl_h) |-> row == ROW_W'((line_y - y_start) >> 1)); // R7

endmodule

// File: rtl/osd_slice_overlay.sv
module osd_slice_overlay
    import osd_pkg::*;
#(
    parameter int NUM_SLICES = 48,
    parameter int SLICE_W    = 8,
    parameter int SLICE_H    = 32,
    parameter int NUM_SLOTS  = 44,
    parameter int CRD_W      = 10,
    parameter int VID_W      = 16,
    localparam int WORD_W    = 2 * SLICE_W,
    localparam int CODE_W    = $clog2(NUM_SLICES),
    localparam int IDX_W     = $clog2(NUM_SLICES * SLICE_H),
    localparam int HA_W      = IDX_W + 2,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int ROW_W     = $clog2(SLICE_H),
    localparam int PIX_W     = $clog2(SLICE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [CRD_W-1:0]  pix_x,
    input  logic [CRD_W-1:0]  line_y,
    input  logic [VID_W-1:0]  vid_in,
    input  logic              vid_valid,
    output logic [VID_W-1:0]  vid_out,
    output logic              vid_out_valid
);

    logic [CRD_W-1:0]  x_start, y_start;
    logic [VID_W-1:0]  colour1, colour2, colour3;
    logic              osd_en, dbl_h;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [WORD_W-1:0] mem_word;
    logic              in_win;
    logic [SLOT_W-1:0] slot;
    logic [ROW_W-1:0]  row;
    logic [PIX_W-1:0]  pix;
    logic [CODE_W-1:0] code;
    logic [WORD_W-1:0] row_word;
    logic [WORD_W-1:0] shifted;
    logic [1:0]        pcode;
    logic              code_bad;

    mix_state_e        state_q, state_d;
    logic [VID_W-1:0]  vid_q;
    logic              valid_q;

    osd_host_regs #(
        .NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W), .CRD_W(CRD_W),
        .VID_W(VID_W), .IDX_W(IDX_W), .HD_W(WORD_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .slot_rd(slot), .code_rd(code),
        .x_start(x_start), .y_start(y_start), .colour1(colour1),
        .colour2(colour2), .colour3(colour3), .osd_en(osd_en), .dbl_h(dbl_h),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_word(mem_word)
    );

    osd_window_locate #(
        .CRD_W(CRD_W), .SLICE_W(SLICE_W), .SLICE_H(SLICE_H), .NUM_SLOTS(NUM_SLOTS)
    ) i_locate (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .line_y(line_y),
        .x_start(x_start), .y_start(y_start), .osd_en(osd_en), .dbl_h(dbl_h),
        .in_win(in_win), .slot(slot), .row(row), .pix(pix)
    );

    osd_slice_store #(
        .NUM_SLICES(NUM_SLICES), .SLICE_H(SLICE_H), .WORD_W(WORD_W)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(mem_we), .wr_idx(mem_idx),
        .wr_word(mem_word), .rd_code(code), .rd_row(row), .rd_word(row_word)
    );

    // pixel code lookup and next mixing state
    always_comb begin
        code_bad = (code >= CODE_W'(NUM_SLICES));
        shifted  = row_word >> (WORD_W - 2 - 2 * int'(pix));
        pcode    = shifted[1:0];
        state_d  = MIX_PASS;
        if (in_win && !code_bad) begin
            unique case (pcode)
                2'd1:    state_d = MIX_C1;
                2'd2:    state_d = MIX_C2;
                2'd3:    state_d = MIX_C3;
                default: state_d = MIX_PASS;
            endcase
        end
    end

    // state register with aligned video copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MIX_IDLE;
            vid_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            vid_q   <= vid_in;
            valid_q <= vid_valid;
        end
    end

    // outputs from state
    always_comb begin
        vid_out_valid = valid_q;
        unique case (state_q)
            MIX_IDLE: vid_out = '0;
            MIX_PASS: vid_out = vid_q;
            MIX_C1:   vid_out = colour1;
            MIX_C2:   vid_out = colour2;
            MIX_C3:   vid_out = colour3;
            default:  vid_out = vid_q;
        endcase
    end

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> vid_out_valid == $past(vid_valid)); // R2

    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_win)) |-> vid_out == $past(vid_in)); // R6

    AST_BAD_CODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(code_bad)) |-> vid_out == $past(vid_in)); // R8

    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(osd_en)) |-> vid_out == $past(vid_in)); // R10

endmodule

// File: tb/test_osd_slice_overlay.sv
module test_osd_slice_overlay;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [12:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [9:0]  pix_x = '0;
    logic [9:0]  line_y = '0;
    logic [15:0] vid_in = '0;
    logic        vid_valid = 1'b0;
    logic [15:0] vid_out;
    logic        vid_out_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] mem_m [1536];
    logic [5:0]  seq_m [44];
    int xs = 0, ys = 0;
    logic [15:0] col_m [4];
    bit en_m = 0, dh_m = 0;

    always #4 clk = ~clk;

    osd_slice_overlay i_osd_slice_overlay (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .pix_x(pix_x), .line_y(line_y),
        .vid_in(vid_in), .vid_valid(vid_valid), .vid_out(vid_out),
        .vid_out_valid(vid_out_valid)
    );

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(int rgn, int idx, logic [15:0] data);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = {2'(rgn), 11'(idx)};
        host_wdata = data;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic set_seq(int s, int code);
        hwrite(1, s, 16'(code));
        if (s < 44) seq_m[s] = 6'(code);
    endtask

    task automatic set_ctrl(bit en, bit dh);
        hwrite(2, 5, {14'd0, dh, en});
        en_m = en;
        dh_m = dh;
    endtask

    function automatic logic [15:0] model(int x, int y, logic [15:0] vin, output string tag);
        int span, slot, p, row, code, pc;
        logic [15:0] w;
        span = dh_m ? 64 : 32;
        if (!en_m) begin tag = "R10"; return vin; end
        if (x < xs || x >= xs + 352 || y < ys || y >= ys + span) begin
            tag = "R6"; return vin;
        end
        slot = (x - xs) / 8;
        p    = (x - xs) % 8;
        row  = dh_m ? (y - ys) / 2 : (y - ys);
        code = int'(seq_m[slot]);
        if (code >= 48) begin tag = "R8"; return vin; end
        w  = mem_m[code * 32 + row];
        pc = int'((w >> (14 - 2 * p)) & 16'h3);
        if (pc == 0) begin tag = "R3"; return vin; end
        tag = dh_m ? "R4/R7" : "R4/R5";
        return col_m[pc];
    endfunction

    task automatic sweep(int y0, int y1, int x1, string ctx);
        for (int y = y0; y <= y1; y++) begin
            for (int x = 0; x <= x1; x++) begin
                logic [15:0] vin, exp;
                bit v;
                string tag;
                @(negedge clk);
                vin = 16'((y * 1021 + x * 17) ^ 16'h5A5A);
                v = ((x + y) % 13) != 0;
                pix_x = 10'(x);
                line_y = 10'(y);
                vid_in = vin;
                vid_valid = v;
                exp = model(x, y, vin, tag);
                @(posedge clk);
                #1;
                check(vid_out == exp, {tag, " ", ctx}, vid_out, exp);
                check(vid_out_valid == v, {"R2 ", ctx}, 16'(vid_out_valid), 16'(v));
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 44; i++) seq_m[i] = 6'h3F;
        col_m[0] = 16'h0000;
        repeat (3) @(posedge clk);
        #1;
        check(vid_out == 16'h0 && vid_out_valid == 1'b0, "R1 during reset", vid_out, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(vid_out == 16'h0 && vid_out_valid == 1'b0, "R1 after reset", vid_out, 16'h0);

        // R1: reset contents pass video even with display enabled
        hwrite(2, 0, 16'd20); xs = 20;
        hwrite(2, 1, 16'd10); ys = 10;
        set_ctrl(1'b1, 1'b0);
        sweep(10, 11, 379, "R1 reset codes transparent");

        // load slices, colours and the sequence
        set_ctrl(1'b0, 1'b0);
        for (int s = 0; s < 48; s++) begin
            for (int r = 0; r < 32; r++) begin
                logic [15:0] w;
                w = 16'(s * 977 + r * 131 + (s ^ r) * 4099 + 7);
                mem_m[s * 32 + r] = w;
                hwrite(0, s * 32 + r, w);
            end
        end
        hwrite(2, 2, 16'hA1A1); col_m[1] = 16'hA1A1;
        hwrite(2, 3, 16'hB2C3); col_m[2] = 16'hB2C3;
        hwrite(2, 4, 16'h0F0E); col_m[3] = 16'h0F0E;
        for (int k = 0; k < 44; k++) set_seq(k, (k * 7 + 3) % 48);
        set_seq(5, 48);
        set_seq(17, 63);
        set_seq(30, 50);
        // R9: out-of-range writes must leave everything untouched
        hwrite(0, 1536, 16'hFFFF);
        hwrite(0, 2047, 16'hFFFF);
        set_seq(44, 0);
        set_seq(63, 1);

        // R10: disabled display passes through
        sweep(10, 12, 379, "R10 disabled");

        // normal height sweep across the whole window and its edges
        set_ctrl(1'b1, 1'b0);
        sweep(8, 43, 379, "R6 normal sweep R9");

        // R5: reorder slots and look again
        set_seq(0, 40);
        set_seq(1, 2);
        set_seq(2, 0);
        set_seq(3, 40);
        sweep(10, 13, 60, "R5 reorder");

        // R7: double height, different origin
        hwrite(2, 0, 16'd3); xs = 3;
        hwrite(2, 1, 16'd5); ys = 5;
        set_ctrl(1'b1, 1'b1);
        sweep(3, 71, 359, "R7 double height");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule